// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block walks a linked chain of transmit descriptors kept in a word-addressed memory. Each descriptor holds four 32-bit words. The walker stays idle until software sets its queue-kick bit. It then fetches descriptors one after another, starting at a loaded head pointer. For every descriptor that the controller owns, it issues a single copy request for the frame's buffer. It then waits for the transmitter to report that the frame is done, writes the completion status back into the descriptor (which also hands the descriptor back to the host), and follows the link pointer to the next descriptor.

The walk stops at the first descriptor the host still owns. At that point the walker clears the kick bit and raises a queue-empty event. If at least one frame was sent since the previous stop, it also raises a chain-complete event. Both events are held in a two-bit sticky status register, which software clears by writing 1 to a bit. Software can append descriptors and set the kick bit again at any moment. The walker then resumes at the descriptor where it stopped, so newly queued frames always go out, and the appended part earns its own chain-complete event.

Top module: `txw_chain_walker`

## Requirements
- R1: Descriptor layout, at byte offsets from the descriptor pointer:
  - +0 is the status word, and its bit 31 is the ownership bit (1 = controller owns it).
  - +4 is the buffer address.
  - +8 is the control word, with the buffer length in bits [15:0] and the fraglist flag in bit 16.
  - +12 is the next-descriptor pointer.
  - The upper bits of the control word are ignored.
- R2: The walker does no memory access until the queue-kick bit (`kick_q_o`) is set by a pulse on `kick_i`. `head_load_i` loads the descriptor pointer only while the walker is idle, and is ignored while a walk is active.
- R3: For each owned descriptor, the walker gives exactly one single-cycle `copy_req_o` pulse. During that pulse, `copy_addr_o` equals word +4, `copy_len_o` equals bits [15:0] of word +8, and `copy_frag_o` equals bit 16 of word +8.
- R4: After `tx_done_i`, the walker writes word +0 back with:
  - bit 31 cleared,
  - bits [15:0] set to `tx_status_i`,
  - bits [30:16] kept as fetched.

  It then fetches the descriptor at word +12 with its two low bits forced to zero. Every memory address it issues is dword aligned.
- R5: When a fetched status word has bit 31 clear, the walker clears the kick bit and sets status bit 0 (queue empty). It reads none of that descriptor's other words and leaves it unmodified, so one walk over N owned descriptors makes 4N+1 reads.
- R6: Status bit 1 (chain complete) is set when the walk stops and at least one frame was sent since the previous stop. It stays clear when the walk stops with no frame sent.
- R7: A kick pulse sets the kick bit even while a walk is active. After a stop, a new kick resumes at the descriptor that stopped the walk. A descriptor appended while the walker is busy is therefore sent, and the appended part sets chain complete again.
- R8: Status bits are sticky. Writing 1 to a bit of `irq_clr_i` clears only that bit. `irq_o` is the OR of the status bits.
- R9: The walker never reads and writes memory in the same cycle.
- R10: After reset, the walker is idle:
  - the kick bit and both status bits are 0;
  - there are no memory accesses;
  - there are no copy requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick_i | input | 1 | Pulse that sets the queue-kick bit |
| head_load_i | input | 1 | Load the descriptor pointer (idle only) |
| head_addr_i | input | AW | Byte address of the first descriptor |
| irq_clr_i | input | 2 | Write-1-to-clear for the status bits |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after `mem_rd_o` |
| copy_req_o | output | 1 | One-cycle frame copy request |
| copy_addr_o | output | 32 | Buffer (or fragment list) address |
| copy_len_o | output | LENW | Buffer length |
| copy_frag_o | output | 1 | Buffer address points to a fragment list |
| tx_done_i | input | 1 | Transmission of the requested frame finished |
| tx_status_i | input | STW | Completion status to write back |
| kick_q_o | output | 1 | Queue-kick bit |
| irq_status_o | output | 2 | Sticky status: bit 0 queue empty, bit 1 chain complete |
| irq_o | output | 1 | OR of the status bits |

## Verification
The assertions assume two things about the memory and the transmitter:
- The memory returns read data exactly one cycle after a read strobe.
- `tx_done_i` pulses only while the walker waits after a copy request.

The bench's memory model is a one-cycle registered array. Its transmitter responder raises done only a few cycles after it sees a copy request, and it can be held back. Descriptor edits made by the bench happen at the falling edge, on words the walker has not yet fetched.

// File: rtl/txw_pkg.sv
package txw_pkg;

    localparam int OWN_BIT   = 31;
    localparam int FRAG_BIT  = 16;
    localparam int NUM_EVT   = 2;
    localparam int EVT_EMPTY = 0;
    localparam int EVT_CHAIN = 1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_REQ,
        S_RD_CAP,
        S_COPY,
        S_WAIT,
        S_WB
    } walk_state_e;

endpackage

// File: rtl/txw_sticky.sv
module txw_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);

    logic [N-1:0] bits_d;
    logic [N-1:0] bits_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_comb begin
            bits_d[g] = set_i[g] | (bits_q[g] & ~clr_i[g]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            bits_q <= bits_d;
        end
    end

    assign q_o = bits_q;

endmodule

// File: rtl/txw_walk_fsm.sv
module txw_walk_fsm
    import txw_pkg::*;
#(
    parameter int AW   = 16,
    parameter int LENW = 16,
    parameter int STW  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            kick_i,
    input  logic            head_load_i,
    input  logic [AW-1:0]   head_addr_i,
    output logic            mem_rd_o,
    output logic            mem_wr_o,
    output logic [AW-1:0]   mem_addr_o,
    output logic [31:0]     mem_wdata_o,
    input  logic [31:0]     mem_rdata_i,
    output logic            copy_req_o,
    output logic [31:0]     copy_addr_o,
    output logic [LENW-1:0] copy_len_o,
    output logic            copy_frag_o,
    input  logic            tx_done_i,
    input  logic [STW-1:0]  tx_status_i,
    output logic            kick_q_o,
    output logic            evt_empty_o,
    output logic            evt_chain_o
);

    localparam int HDRW = OWN_BIT - STW;
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);

    typedef struct packed {
        walk_state_e     st;
        logic [1:0]      idx;
        logic [AW-1:0]   ptr;
        logic [HDRW-1:0] hdr;
        logic [31:0]     buf_addr;
        logic [LENW-1:0] len;
        logic            frag;
        logic [AW-1:0]   next;
        logic [STW-1:0]  status;
        logic            sent;
        logic            kick;
    } walk_t;

    walk_t walk_d;
    walk_t walk_q;

    always_comb begin
        walk_d      = walk_q;
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        mem_addr_o  = walk_q.ptr;
        mem_wdata_o = {1'b0, walk_q.hdr, walk_q.status};
        copy_req_o  = 1'b0;
        evt_empty_o = 1'b0;
        evt_chain_o = 1'b0;

        unique case (walk_q.st)
            S_IDLE: begin
                if (head_load_i) begin
                    walk_d.ptr = head_addr_i & ALIGN_MASK;
                end
                if (walk_q.kick) begin
                    walk_d.idx = 2'd0;
                    walk_d.st  = S_RD_REQ;
                end
            end
            S_RD_REQ: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = walk_q.ptr + AW'({walk_q.idx, 2'b00});
                walk_d.st  = S_RD_CAP;
            end
            S_RD_CAP: begin
                unique case (walk_q.idx)
                    2'd0: walk_d.hdr      = mem_rdata_i[OWN_BIT-1:STW];
                    2'd1: walk_d.buf_addr = mem_rdata_i;
                    2'd2: begin
                        walk_d.len  = mem_rdata_i[LENW-1:0];
                        walk_d.frag = mem_rdata_i[FRAG_BIT];
                    end
                    default: walk_d.next = mem_rdata_i[AW-1:0] & ALIGN_MASK;
                endcase
                if (walk_q.idx == 2'd0 && !mem_rdata_i[OWN_BIT]) begin
                    walk_d.kick = 1'b0;
                    walk_d.sent = 1'b0;
                    walk_d.st   = S_IDLE;
                    evt_empty_o = 1'b1;
                    evt_chain_o = walk_q.sent;
                end else if (walk_q.idx == 2'd3) begin
                    walk_d.st = S_COPY;
                end else begin
                    walk_d.idx = walk_q.idx + 2'd1;
                    walk_d.st  = S_RD_REQ;
                end
            end
            S_COPY: begin
                copy_req_o = 1'b1;
                walk_d.st  = S_WAIT;
            end
            S_WAIT: begin
                if (tx_done_i) begin
                    walk_d.status = tx_status_i;
                    walk_d.st     = S_WB;
                end
            end
            S_WB: begin
                mem_wr_o    = 1'b1;
                walk_d.ptr  = walk_q.next;
                walk_d.sent = 1'b1;
                walk_d.idx  = 2'd0;
                walk_d.st   = S_RD_REQ;
            end
            default: walk_d.st = S_IDLE;
        endcase

        if (kick_i) begin
            walk_d.kick = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '{st: S_IDLE, default: '0};
        end else begin
            walk_q <= walk_d;
        end
    end

    assign copy_addr_o = walk_q.buf_addr;
    assign copy_len_o  = walk_q.len;
    assign copy_frag_o = walk_q.frag;
    assign kick_q_o    = walk_q.kick;

endmodule

// File: rtl/txw_chain_walker.sv
module txw_chain_walker
    import txw_pkg::*;
#(
    parameter int AW   = 16,
    parameter int LENW = 16,
    parameter int STW  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               kick_i,
    input  logic               head_load_i,
    input  logic [AW-1:0]      head_addr_i,
    input  logic [NUM_EVT-1:0] irq_clr_i,
    output logic               mem_rd_o,
    output logic               mem_wr_o,
    output logic [AW-1:0]      mem_addr_o,
    output logic [31:0]        mem_wdata_o,
    input  logic [31:0]        mem_rdata_i,
    output logic               copy_req_o,
    output logic [31:0]        copy_addr_o,
    output logic [LENW-1:0]    copy_len_o,
    output logic               copy_frag_o,
    input  logic               tx_done_i,
    input  logic [STW-1:0]     tx_status_i,
    output logic               kick_q_o,
    output logic [NUM_EVT-1:0] irq_status_o,
    output logic               irq_o
);

    logic               empty_evt;
    logic               chain_evt;
    logic [NUM_EVT-1:0] evt_vec;

    txw_walk_fsm #(
        .AW   (AW),
        .LENW (LENW),
        .STW  (STW)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .kick_i      (kick_i),
        .head_load_i (head_load_i),
        .head_addr_i (head_addr_i),
        .mem_rd_o    (mem_rd_o),
        .mem_wr_o    (mem_wr_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rdata_i (mem_rdata_i),
        .copy_req_o  (copy_req_o),
        .copy_addr_o (copy_addr_o),
        .copy_len_o  (copy_len_o),
        .copy_frag_o (copy_frag_o),
        .tx_done_i   (tx_done_i),
        .tx_status_i (tx_status_i),
        .kick_q_o    (kick_q_o),
        .evt_empty_o (empty_evt),
        .evt_chain_o (chain_evt)
    );

    always_comb begin
        evt_vec            = '0;
        evt_vec[EVT_EMPTY] = empty_evt;
        evt_vec[EVT_CHAIN] = chain_evt;
    end

    txw_sticky #(
        .N (NUM_EVT)
    ) i_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_vec),
        .clr_i (irq_clr_i),
        .q_o   (irq_status_o)
    );

    assign irq_o = |irq_status_o;

endmodule

// File: rtl/txw_walker_chk.sv
module txw_walker_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          kick_i,
    input logic [1:0]    irq_clr_i,
    input logic          mem_rd_o,
    input logic          mem_wr_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [31:0]   mem_wdata_o,
    input logic          copy_req_o,
    input logic          kick_q_o,
    input logic [1:0]    irq_status_o,
    input logic          empty_evt,
    input logic          chain_evt
);

    a_r9_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || mem_wr_o) |-> (mem_addr_o[1:0] == 2'b00));

    a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        copy_req_o |=> !copy_req_o);

    a_r4_owner_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> !mem_wdata_o[31]);

    a_r4_next_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |=> mem_rd_o);

    a_r5_kick_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_evt && !kick_i) |=> !kick_q_o);

    a_r6_chain_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        chain_evt |-> empty_evt);

    a_r8_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr_i[0] && !empty_evt) |=> !irq_status_o[0]);

    a_r8_set_empty: assert property (@(posedge clk) disable iff (!rst_n)
        empty_evt |=> irq_status_o[0]);

endmodule

bind txw_chain_walker txw_walker_chk #(.AW(AW)) i_walker_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .kick_i       (kick_i),
    .irq_clr_i    (irq_clr_i),
    .mem_rd_o     (mem_rd_o),
    .mem_wr_o     (mem_wr_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .copy_req_o   (copy_req_o),
    .kick_q_o     (kick_q_o),
    .irq_status_o (irq_status_o),
    .empty_evt    (empty_evt),
    .chain_evt    (chain_evt)
);

// File: tb/test_txw_chain_walker.sv
module test_txw_chain_walker;

    localparam int AW = 16;
    localparam int LENW = 16;
    localparam int STW = 16;

    typedef struct packed {
        logic [15:0] head;
        logic [2:0]  n_own;
        logic [3:0]  frag_mask;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{head: 16'h0040, n_own: 3'd3, frag_mask: 4'b0010},
        '{head: 16'h0100, n_own: 3'd1, frag_mask: 4'b0001},
        '{head: 16'h0080, n_own: 3'd0, frag_mask: 4'b0000},
        '{head: 16'h0020, n_own: 3'd4, frag_mask: 4'b1001}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            kick = 1'b0;
    logic            head_load = 1'b0;
    logic [AW-1:0]   head_addr = '0;
    logic [1:0]      irq_clr = 2'b00;
    logic            mem_rd;
    logic            mem_wr;
    logic [AW-1:0]   mem_addr;
    logic [31:0]     mem_wdata;
    logic [31:0]     mem_rdata = '0;
    logic            copy_req;
    logic [31:0]     copy_addr;
    logic [LENW-1:0] copy_len;
    logic            copy_frag;
    logic            tx_done = 1'b0;
    logic [STW-1:0]  tx_status = '0;
    logic            kick_q;
    logic [1:0]      irq_status;
    logic            irq;

    logic [31:0] mem [256];
    logic [31:0] log_addr [16];
    logic [15:0] log_len [16];
    logic        log_frag [16];
    int          log_n = 0;
    int          n_reads = 0;
    int          n_viol = 0;
    int          n_checks = 0;
    int          n_fails = 0;
    logic        hold_done = 1'b0;
    logic        done_run = 1'b0;

    always #2 clk = ~clk;

    txw_chain_walker #(.AW(AW), .LENW(LENW), .STW(STW)) i_txw_chain_walker (
        .clk          (clk),
        .rst_n        (rst_n),
        .kick_i       (kick),
        .head_load_i  (head_load),
        .head_addr_i  (head_addr),
        .irq_clr_i    (irq_clr),
        .mem_rd_o     (mem_rd),
        .mem_wr_o     (mem_wr),
        .mem_addr_o   (mem_addr),
        .mem_wdata_o  (mem_wdata),
        .mem_rdata_i  (mem_rdata),
        .copy_req_o   (copy_req),
        .copy_addr_o  (copy_addr),
        .copy_len_o   (copy_len),
        .copy_frag_o  (copy_frag),
        .tx_done_i    (tx_done),
        .tx_status_i  (tx_status),
        .kick_q_o     (kick_q),
        .irq_status_o (irq_status),
        .irq_o        (irq)
    );

    // one-cycle registered memory
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
    end

    // monitor
    always @(negedge clk) begin
        if (mem_rd) n_reads = n_reads + 1;
        if (mem_rd && mem_wr) n_viol = n_viol + 1;
        if ((mem_rd || mem_wr) && mem_addr[1:0] != 2'b00) n_viol = n_viol + 1;
        if (copy_req && log_n < 16) begin
            log_addr[log_n] = copy_addr;
            log_len[log_n]  = copy_len;
            log_frag[log_n] = copy_frag;
            log_n = log_n + 1;
        end
    end

    // transmitter responder
    initial begin
        forever begin
            @(negedge clk);
            if (copy_req) begin
                tx_status = copy_addr[15:0] ^ 16'h5A5A;
                while (hold_done) @(negedge clk);
                repeat (3) @(negedge clk);
                tx_done = 1'b1;
                @(negedge clk);
                tx_done = 1'b0;
            end
        end
    end

    task automatic finish_run();
        if (!done_run) begin
            done_run = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails = n_fails + 1;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fails = n_fails + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int k = 0; k < 256; k++) mem[k] = 32'h0;
    endtask

    task automatic pulse_kick();
        @(negedge clk) kick = 1'b1;
        @(negedge clk) kick = 1'b0;
    endtask

    task automatic load_head(input logic [15:0] a);
        @(negedge clk) begin head_load = 1'b1; head_addr = a; end
        @(negedge clk) head_load = 1'b0;
    endtask

    task automatic clear_irq(input logic [1:0] m);
        @(negedge clk) irq_clr = m;
        @(negedge clk) irq_clr = 2'b00;
    endtask

    task automatic wait_empty();
        for (int k = 0; k < 3000 && !irq_status[0]; k++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [15:0] daddr(input logic [15:0] head, input int i);
        return head + 16'(i * 32);
    endfunction

    function automatic logic [31:0] w1_of(input logic [15:0] head, input int i);
        return 32'hB000_0000 + (32'(head) << 8) + 32'(i * 16);
    endfunction

    task automatic build_chain(input vec_t v);
        for (int i = 0; i <= int'(v.n_own); i++) begin
            logic [15:0] a;
            a = daddr(v.head, i);
            if (i < int'(v.n_own)) begin
                mem[a[9:2]] = {1'b1, 15'(16'h00A0 + i), 16'h0000};
            end else begin
                mem[a[9:2]] = 32'h0000_1234;
            end
            mem[a[9:2] + 8'd1] = w1_of(v.head, i);
            mem[a[9:2] + 8'd2] = 32'hF0E0_0000 | (32'(v.frag_mask[i % 4]) << 16)
                                 | 32'(16'(100 + int'(v.head) + i));
            mem[a[9:2] + 8'd3] = {16'h0, daddr(v.head, i + 1)} | 32'(i % 3);
        end
    endtask

    initial begin
        // R10 reset state
        repeat (3) @(negedge clk);
        check("R10 kick after reset", 32'(kick_q), 32'h0);
        check("R10 status after reset", 32'(irq_status), 32'h0);
        check("R10 no copy request", 32'(copy_req), 32'h0);
        check("R10 no memory read", 32'(mem_rd), 32'h0);
        @(negedge clk) rst_n = 1'b1;

        // R2: no kick, no access
        clear_mem();
        load_head(16'h0040);
        repeat (20) @(negedge clk);
        check("R2 no reads without kick", 32'(n_reads), 32'h0);
        check("R2 irq idle without kick", 32'(irq), 32'h0);

        // table-driven walks
        for (int t = 0; t < 4; t++) begin
            vec_t v;
            v = VECS[t];
            clear_mem();
            build_chain(v);
            log_n = 0;
            n_reads = 0;
            load_head(v.head);
            pulse_kick();
            wait_empty();
            check("R3 copy count", 32'(log_n), 32'(v.n_own));
            check("R5 reads 4N+1", 32'(n_reads), 32'(4 * int'(v.n_own) + 1));
            for (int i = 0; i < int'(v.n_own); i++) begin
                logic [15:0] a;
                a = daddr(v.head, i);
                check("R1 R3 copy address", log_addr[i], w1_of(v.head, i));
                check("R1 R3 copy length", 32'(log_len[i]), 32'(16'(100 + int'(v.head) + i)));
                check("R1 R3 fraglist flag", 32'(log_frag[i]), 32'(v.frag_mask[i % 4]));
                check("R4 status write back", mem[a[9:2]],
                      {1'b0, 15'(16'h00A0 + i), w1_of(v.head, i)[15:0] ^ 16'h5A5A});
            end
            begin
                logic [15:0] te;
                te = daddr(v.head, int'(v.n_own));
                check("R5 stop descriptor untouched", mem[te[9:2]], 32'h0000_1234);
            end
            check("R5 kick cleared", 32'(kick_q), 32'h0);
            check("R5 queue empty set", 32'(irq_status[0]), 32'h1);
            check("R6 chain complete", 32'(irq_status[1]), 32'(v.n_own != 3'd0));
            check("R4 R9 access rules", 32'(n_viol), 32'h0);
            clear_irq(2'b11);
            check("R8 cleared by write 1", 32'(irq_status), 32'h0);
            check("R8 irq low", 32'(irq), 32'h0);
        end

        // R7 kick while active, R2 head load ignored while busy
        clear_mem();
        mem[8'h80] = {1'b1, 15'h0077, 16'h0};
        mem[8'h81] = 32'hC0DE_0200;
        mem[8'h82] = 32'd50;
        mem[8'h83] = 32'h0000_0220;
        mem[8'h88] = 32'h0;
        mem[8'h8B] = 32'h0000_0240;
        mem[8'h90] = 32'h0000_5555;
        log_n = 0;
        n_reads = 0;
        hold_done = 1'b1;
        load_head(16'h0200);
        pulse_kick();
        for (int k = 0; k < 500 && log_n == 0; k++) @(negedge clk);
        mem[8'h88] = {1'b1, 15'h00B0, 16'h0};
        mem[8'h89] = 32'hC0DE_0220;
        mem[8'h8A] = 32'd77;
        @(negedge clk) begin kick = 1'b1; head_load = 1'b1; head_addr = 16'h0300; end
        @(negedge clk) begin kick = 1'b0; head_load = 1'b0; end
        check("R7 kick set while active", 32'(kick_q), 32'h1);
        hold_done = 1'b0;
        wait_empty();
        check("R7 appended frame sent", 32'(log_n), 32'h2);
        check("R7 appended copy address", log_addr[1], 32'hC0DE_0220);
        check("R2 head load ignored while busy", 32'(n_reads), 32'd9);
        check("R7 appended written back", mem[8'h88], {1'b0, 15'h00B0, 16'h0220 ^ 16'h5A5A});
        check("R5 kick cleared after resume", 32'(kick_q), 32'h0);
        clear_irq(2'b11);

        // R7 resume after stop: chain complete twice, R8 per-bit clear
        clear_mem();
        mem[8'h00] = {1'b1, 15'h0011, 16'h0};
        mem[8'h01] = 32'hAAAA_0000;
        mem[8'h02] = 32'd10;
        mem[8'h03] = 32'h0000_0020;
        mem[8'h08] = 32'h0;
        mem[8'h0B] = 32'h0000_0040;
        log_n = 0;
        load_head(16'h0000);
        pulse_kick();
        wait_empty();
        check("R6 first chain complete", 32'(irq_status[1]), 32'h1);
        clear_irq(2'b01);
        check("R8 only bit0 cleared", 32'(irq_status), 32'h2);
        check("R8 irq still high", 32'(irq), 32'h1);
        clear_irq(2'b10);
        check("R8 bit1 cleared", 32'(irq_status), 32'h0);
        mem[8'h08] = {1'b1, 15'h0022, 16'h0};
        mem[8'h09] = 32'hAAAA_0020;
        mem[8'h0A] = 32'd20;
        pulse_kick();
        wait_empty();
        check("R7 second chain complete", 32'(irq_status[1]), 32'h1);
        check("R7 resumed frame sent", 32'(log_n), 32'h2);
        check("R7 resumed copy address", log_addr[1], 32'hAAAA_0020);
        check("R7 resumed write back", mem[8'h08], {1'b0, 15'h0022, 16'h0020 ^ 16'h5A5A});
        check("R9 no read-write overlap", 32'(n_viol), 32'h0);

        finish_run();
    end

endmodule